// File: doc/BRIEF.md
# Receive Elastic Buffer Reset Controller

This block decides when the elastic buffer of a serial receiver is flushed. It runs in the receive user clock domain. It combines three kinds of cause into one buffer-reset pulse. The first is a set of asynchronous resets: the receive system reset, the clock-recovery reset and the full receiver reset. The second is a manual flush request. The third is a group of automatic triggers, each switched on by its own static configuration bit:

- a change of the rate select,
- a change of the channel-bonding role or level,
- a comma realignment,
- loss of a qualified serial signal.

Signal presence is qualified from a raw activity indication with two run-length thresholds. Realignment flushes can be restricted to times when the line is qualified valid and the electrical-idle indicator is clear.

The pulse has a fixed minimum length. A trigger that arrives while a pulse is running restarts the count instead of producing a second pulse. A registered reset-done output reports that the buffer is usable. It is high only when no pulse is running, the block is out of reset, and the second user clock has been seen toggling recently.

Top module: `rxbuf_rst_ctrl`

## Requirements
- R1: `buf_rst_req_i` is asynchronous and passes through a 2-stage synchronizer. A request held for N clock cycles keeps `buf_rst_o` high for N+3 cycles. The first high sample is the third clock after the request rises.
- R2: With `cfg_en_rate_i` = 1, any change of `rate_sel_i` starts a pulse on the next clock. With the bit at 0, a change leaves `buf_rst_o` low.
- R3: With `cfg_en_bond_i` = 1, a change of `bond_master_i`, `bond_slave_i` or `bond_level_i` starts a pulse on the next clock. With the bit at 0, a change is ignored.
- R4: With `cfg_en_realign_i` = 1, a one-cycle `realign_i` starts a pulse on the next clock, subject to R5. With the bit at 0, it is ignored.
- R5: With `cfg_realign_ungated_i` = 0, a realignment starts a pulse only if the line is qualified valid and `elec_idle_i` = 0. With the bit at 1, it fires regardless of either.
- R6: The line becomes valid after `cfg_hi_thr_i` consecutive clocks with `sig_raw_i` = 1. It becomes invalid after `cfg_lo_thr_i` consecutive clocks with `sig_raw_i` = 0. Shorter runs leave the state unchanged. After reset the line is invalid.
- R7: With `cfg_en_idle_i` = 1, an invalid line restarts the pulse on every clock. `buf_rst_o` therefore stays high until PULSE_LEN-1 clocks after the line becomes valid again.
- R8: Any of `sys_rst_i`, `cdr_rst_i` and `rx_full_rst_i` forces `buf_rst_o` high and `rst_done_o` low at once. After the last of them falls, `buf_rst_o` stays high for SYNC_STAGES+PULSE_LEN-1 more clocks.
- R9: One trigger cycle gives a pulse of exactly PULSE_LEN (4) clocks. A trigger during a pulse reloads the count. Two triggers K clocks apart therefore give K+PULSE_LEN high clocks.
- R10: `rst_done_o` rises one clock after `buf_rst_o` falls, and only if `usr_clk2_i` has toggled within the last ACT_WIN clocks. It falls when that clock stays idle and is low whenever a pulse is running.
- R11: Values of the rate and bonding inputs that changed while reset was held do not produce a trigger after reset release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Receive user clock; all logic runs on it |
| usr_clk2_i | input | 1 | Second receive user clock, monitored for activity |
| sys_rst_i | input | 1 | Asynchronous receive system reset, active high |
| cdr_rst_i | input | 1 | Asynchronous clock-recovery reset, active high |
| rx_full_rst_i | input | 1 | Asynchronous full receiver reset, active high |
| buf_rst_req_i | input | 1 | Asynchronous manual buffer flush request |
| rate_sel_i | input | RATE_W | Rate select, watched for changes |
| bond_master_i | input | 1 | Bonding master role flag |
| bond_slave_i | input | 1 | Bonding slave role flag |
| bond_level_i | input | LVL_W | Bonding level |
| realign_i | input | 1 | One-cycle comma realignment event |
| elec_idle_i | input | 1 | Electrical-idle indicator |
| sig_raw_i | input | 1 | Raw per-cycle line activity indication |
| cfg_en_rate_i | input | 1 | Enable of the rate-change trigger |
| cfg_en_bond_i | input | 1 | Enable of the bonding-change trigger |
| cfg_en_realign_i | input | 1 | Enable of the realignment trigger |
| cfg_realign_ungated_i | input | 1 | 1: realignment trigger ignores validity and idle |
| cfg_en_idle_i | input | 1 | Enable of the invalid-line trigger |
| cfg_hi_thr_i | input | CNT_W | High run needed to declare the line valid |
| cfg_lo_thr_i | input | CNT_W | Low run needed to declare the line invalid |
| buf_rst_o | output | 1 | Buffer pointer reset pulse |
| rst_done_o | output | 1 | Buffer ready status |

## Verification
The assertions assume the following about the inputs:

- The rate, bonding, realignment, electrical-idle and raw-activity inputs are already synchronous to `clk_i`.
- The configuration bits do not change within a cycle in which a trigger is being judged.
- `realign_i` is a single-cycle strobe.

The bench drives all of these on the falling edge of `clk_i` and changes configuration only while the block has been quiet for several cycles. It asserts and releases the resets and the manual request on falling edges. It runs `usr_clk2_i` at half rate with edges offset from `clk_i`, so the activity monitor never sees a sampling race.

// File: rtl/rxb_pkg.sv
package rxb_pkg;

  // One bit per automatic or manual flush cause.
  typedef struct packed {
    logic manual;
    logic rate;
    logic bond;
    logic realign;
    logic idle;
  } trig_t;

  // Saturating increment used by every run or idle counter.
  function automatic int unsigned sat_inc(input int unsigned v, input int unsigned lim);
    return (v >= lim) ? lim : v + 1;
  endfunction

  // True when one more cycle of the current run reaches the threshold.
  function automatic logic run_reaches(input int unsigned run, input int unsigned thr);
    return (run + 1) >= thr;
  endfunction

  // Next value of the pulse counter: reload on a cause, else count down to 0.
  function automatic int unsigned pulse_next(input int unsigned cnt, input logic load,
                                             input int unsigned len);
    if (load) return len;
    return (cnt == 0) ? 0 : cnt - 1;
  endfunction

endpackage

// File: rtl/rxb_sync.sv
module rxb_sync #(
  parameter int   W       = 1,
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic         clk,
  input  logic         arst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] stg;

  always_ff @(posedge clk or posedge arst) begin
    if (arst) stg <= {STAGES{{W{RST_VAL}}}};
    else      stg <= {stg[STAGES-2:0], d};
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/rxb_chg_det.sv
module rxb_chg_det #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         arst,
  input  logic         arm,
  input  logic [W-1:0] d,
  output logic         chg
);
  logic [W-1:0] prev_q;

  // The previous value is captured every cycle, also while disarmed,
  // so values applied during reset never look like a change.
  always_ff @(posedge clk or posedge arst) begin
    if (arst) prev_q <= '0;
    else      prev_q <= d;
  end

  logic [W-1:0] diff;
  for (genvar i = 0; i < W; i++) begin : g_bit
    assign diff[i] = d[i] ^ prev_q[i];
  end

  assign chg = arm & (|diff);
endmodule

// File: rtl/rxb_sigqual.sv
module rxb_sigqual #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             arst,
  input  logic             raw,
  input  logic [CNT_W-1:0] hi_thr,
  input  logic [CNT_W-1:0] lo_thr,
  output logic             valid
);
  localparam int unsigned RUN_MAX = (1 << CNT_W) - 1;

  logic [CNT_W-1:0] hi_run;
  logic [CNT_W-1:0] lo_run;
  logic             hi_hit;
  logic             lo_hit;

  assign hi_hit = rxb_pkg::run_reaches(32'(hi_run), 32'(hi_thr));
  assign lo_hit = rxb_pkg::run_reaches(32'(lo_run), 32'(lo_thr));

  always_ff @(posedge clk or posedge arst) begin
    if (arst) begin
      hi_run <= '0;
      lo_run <= '0;
      valid  <= 1'b0;
    end else if (raw) begin
      lo_run <= '0;
      hi_run <= CNT_W'(rxb_pkg::sat_inc(32'(hi_run), RUN_MAX));
      if (hi_hit) valid <= 1'b1;
    end else begin
      hi_run <= '0;
      lo_run <= CNT_W'(rxb_pkg::sat_inc(32'(lo_run), RUN_MAX));
      if (lo_hit) valid <= 1'b0;
    end
  end
endmodule

// File: rtl/rxb_clkmon.sv
module rxb_clkmon #(
  parameter int SYNC_STAGES = 2,
  parameter int ACT_WIN     = 8
) (
  input  logic clk,
  input  logic arst,
  input  logic clk2,
  output logic ok
);
  generate
    if (ACT_WIN == 0) begin : g_off
      assign ok = 1'b1;
    end else begin : g_mon
      localparam int IW = $clog2(ACT_WIN + 1);

      logic tog_q;
      logic tog_s;
      logic tog_d;
      logic seen;
      logic [IW-1:0] idle_q;

      // Toggle flop in the second clock domain.
      always_ff @(posedge clk2 or posedge arst) begin
        if (arst) tog_q <= 1'b0;
        else      tog_q <= ~tog_q;
      end

      rxb_sync #(.W(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_tog_sync (
        .clk (clk),
        .arst(arst),
        .d   (tog_q),
        .q   (tog_s)
      );

      always_ff @(posedge clk or posedge arst) begin
        if (arst) tog_d <= 1'b0;
        else      tog_d <= tog_s;
      end

      assign seen = tog_s ^ tog_d;

      always_ff @(posedge clk or posedge arst) begin
        if (arst)      idle_q <= IW'(ACT_WIN);
        else if (seen) idle_q <= '0;
        else           idle_q <= IW'(rxb_pkg::sat_inc(32'(idle_q), ACT_WIN));
      end

      assign ok = (idle_q < IW'(ACT_WIN));
    end
  endgenerate
endmodule

// File: rtl/rxb_pulse.sv
module rxb_pulse #(
  parameter int LEN = 4
) (
  input  logic clk,
  input  logic arst,
  input  logic hold,
  input  logic trig,
  output logic active
);
  localparam int CW = $clog2(LEN + 1);

  logic [CW-1:0] cnt_q;

  // Reset leaves the counter loaded so the pulse covers the release window.
  always_ff @(posedge clk or posedge arst) begin
    if (arst) cnt_q <= CW'(LEN);
    else      cnt_q <= CW'(rxb_pkg::pulse_next(32'(cnt_q), hold | trig, LEN));
  end

  assign active = (cnt_q != '0);
endmodule

// File: rtl/rxbuf_rst_ctrl.sv
module rxbuf_rst_ctrl #(
  parameter int RATE_W      = 2,
  parameter int LVL_W       = 3,
  parameter int CNT_W       = 4,
  parameter int PULSE_LEN   = 4,
  parameter int SYNC_STAGES = 2,
  parameter int ACT_WIN     = 8
) (
  input  logic              clk_i,
  input  logic              usr_clk2_i,
  input  logic              sys_rst_i,
  input  logic              cdr_rst_i,
  input  logic              rx_full_rst_i,
  input  logic              buf_rst_req_i,
  input  logic [RATE_W-1:0] rate_sel_i,
  input  logic              bond_master_i,
  input  logic              bond_slave_i,
  input  logic [LVL_W-1:0]  bond_level_i,
  input  logic              realign_i,
  input  logic              elec_idle_i,
  input  logic              sig_raw_i,
  input  logic              cfg_en_rate_i,
  input  logic              cfg_en_bond_i,
  input  logic              cfg_en_realign_i,
  input  logic              cfg_realign_ungated_i,
  input  logic              cfg_en_idle_i,
  input  logic [CNT_W-1:0]  cfg_hi_thr_i,
  input  logic [CNT_W-1:0]  cfg_lo_thr_i,
  output logic              buf_rst_o,
  output logic              rst_done_o
);
  localparam int BOND_W = LVL_W + 2;

  // Named internal events, used by the checker.
  logic          areset;
  logic          rst_sync;
  logic          req_sync;
  logic          armed;
  logic          chg_rate;
  logic          chg_bond;
  logic          sig_valid;
  logic          clk_ok;
  logic          realign_ok;
  logic          trig_any;
  logic          pulse_active;
  logic          done_q;
  rxb_pkg::trig_t trig;

  assign areset = sys_rst_i | cdr_rst_i | rx_full_rst_i;

  // Asynchronous assert, synchronized release.
  rxb_sync #(.W(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_rst_sync (
    .clk (clk_i),
    .arst(areset),
    .d   (1'b0),
    .q   (rst_sync)
  );

  rxb_sync #(.W(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_req_sync (
    .clk (clk_i),
    .arst(areset),
    .d   (buf_rst_req_i),
    .q   (req_sync)
  );

  always_ff @(posedge clk_i or posedge areset) begin
    if (areset) armed <= 1'b0;
    else        armed <= ~rst_sync;
  end

  rxb_chg_det #(.W(RATE_W)) u_rate_chg (
    .clk (clk_i),
    .arst(areset),
    .arm (armed),
    .d   (rate_sel_i),
    .chg (chg_rate)
  );

  rxb_chg_det #(.W(BOND_W)) u_bond_chg (
    .clk (clk_i),
    .arst(areset),
    .arm (armed),
    .d   ({bond_master_i, bond_slave_i, bond_level_i}),
    .chg (chg_bond)
  );

  rxb_sigqual #(.CNT_W(CNT_W)) u_sigqual (
    .clk   (clk_i),
    .arst  (areset),
    .raw   (sig_raw_i),
    .hi_thr(cfg_hi_thr_i),
    .lo_thr(cfg_lo_thr_i),
    .valid (sig_valid)
  );

  rxb_clkmon #(.SYNC_STAGES(SYNC_STAGES), .ACT_WIN(ACT_WIN)) u_clkmon (
    .clk (clk_i),
    .arst(areset),
    .clk2(usr_clk2_i),
    .ok  (clk_ok)
  );

  assign realign_ok   = cfg_realign_ungated_i | (sig_valid & ~elec_idle_i);

  assign trig.manual  = req_sync;
  assign trig.rate    = cfg_en_rate_i & chg_rate;
  assign trig.bond    = cfg_en_bond_i & chg_bond;
  assign trig.realign = cfg_en_realign_i & realign_i & realign_ok;
  assign trig.idle    = cfg_en_idle_i & ~sig_valid;
  assign trig_any     = |trig;

  rxb_pulse #(.LEN(PULSE_LEN)) u_pulse (
    .clk   (clk_i),
    .arst  (areset),
    .hold  (rst_sync),
    .trig  (trig_any),
    .active(pulse_active)
  );

  always_ff @(posedge clk_i or posedge areset) begin
    if (areset) done_q <= 1'b0;
    else        done_q <= ~pulse_active & ~rst_sync & clk_ok;
  end

  assign buf_rst_o  = pulse_active;
  assign rst_done_o = done_q;
endmodule

// File: rtl/rxbuf_rst_ctrl_chk.sv
module rxbuf_rst_ctrl_chk #(
  parameter int LEN = 4
) (
  input logic clk,
  input logic areset,
  input logic rst_sync,
  input logic buf_rst,
  input logic done,
  input logic clk_ok,
  input logic chg_rate,
  input logic chg_bond,
  input logic en_rate,
  input logic en_bond,
  input logic en_idle,
  input logic sig_valid,
  input logic trig_any
);
  logic [7:0] hi_run;

  always_ff @(posedge clk or posedge areset) begin
    if (areset)       hi_run <= '0;
    else if (buf_rst) hi_run <= (hi_run == 8'hFF) ? hi_run : hi_run + 8'd1;
    else              hi_run <= '0;
  end

  assert_rate_trig_R2: assert property (@(posedge clk) disable iff (areset)
    (en_rate && chg_rate) |=> buf_rst);

  assert_bond_trig_R3: assert property (@(posedge clk) disable iff (areset)
    (en_bond && chg_bond) |=> buf_rst);

  assert_idle_hold_R7: assert property (@(posedge clk) disable iff (areset)
    (en_idle && !sig_valid) |=> buf_rst);

  assert_release_pulse_R8: assert property (@(posedge clk) disable iff (areset)
    rst_sync |=> buf_rst);

  assert_min_len_R9: assert property (@(posedge clk) disable iff (areset)
    $fell(buf_rst) |-> (int'(hi_run) >= LEN));

  assert_pulse_cause_R9: assert property (@(posedge clk) disable iff (areset)
    $rose(buf_rst) |-> $past(trig_any || rst_sync));

  assert_done_after_pulse_R10: assert property (@(posedge clk) disable iff (areset)
    buf_rst |=> !done);

  assert_done_needs_clk_R10: assert property (@(posedge clk) disable iff (areset)
    done |-> $past(clk_ok));
endmodule

bind rxbuf_rst_ctrl rxbuf_rst_ctrl_chk #(.LEN(PULSE_LEN)) u_chk (
  .clk      (clk_i),
  .areset   (areset),
  .rst_sync (rst_sync),
  .buf_rst  (buf_rst_o),
  .done     (rst_done_o),
  .clk_ok   (clk_ok),
  .chg_rate (chg_rate),
  .chg_bond (chg_bond),
  .en_rate  (cfg_en_rate_i),
  .en_bond  (cfg_en_bond_i),
  .en_idle  (cfg_en_idle_i),
  .sig_valid(sig_valid),
  .trig_any (trig_any)
);

// File: tb/sim_rxbuf_rst_ctrl.sv
module sim_rxbuf_rst_ctrl;
  localparam int LEN  = 4;
  localparam int SYNC = 2;
  localparam int HI   = 3;
  localparam int LO   = 5;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic clk2     = 1'b0;
  bit   clk2_run = 1'b1;
  initial begin
    #5;
    forever begin
      #20;
      if (clk2_run) clk2 = ~clk2;
    end
  end

  logic       sys_rst = 1'b1, cdr_rst = 1'b1, full_rst = 1'b1;
  logic       req = 1'b0;
  logic [1:0] rate_sel = 2'd0;
  logic       b_master = 1'b0, b_slave = 1'b0;
  logic [2:0] b_level = 3'd0;
  logic       realign = 1'b0, eidle = 1'b0, raw = 1'b1;
  logic       en_rate = 1'b0, en_bond = 1'b0, en_realign = 1'b0, ungated = 1'b0, en_idle = 1'b0;
  logic [3:0] hi_thr = 4'(HI), lo_thr = 4'(LO);
  logic       buf_rst, done;

  rxbuf_rst_ctrl u0 (
    .clk_i(clk), .usr_clk2_i(clk2),
    .sys_rst_i(sys_rst), .cdr_rst_i(cdr_rst), .rx_full_rst_i(full_rst),
    .buf_rst_req_i(req), .rate_sel_i(rate_sel),
    .bond_master_i(b_master), .bond_slave_i(b_slave), .bond_level_i(b_level),
    .realign_i(realign), .elec_idle_i(eidle), .sig_raw_i(raw),
    .cfg_en_rate_i(en_rate), .cfg_en_bond_i(en_bond), .cfg_en_realign_i(en_realign),
    .cfg_realign_ungated_i(ungated), .cfg_en_idle_i(en_idle),
    .cfg_hi_thr_i(hi_thr), .cfg_lo_thr_i(lo_thr),
    .buf_rst_o(buf_rst), .rst_done_o(done)
  );

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  task automatic chk(input bit ok, input string req_tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual=%0d expected=%0d", req_tag, act, exp);
    end
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Counts consecutive high samples of buf_rst from the next falling edge on.
  task automatic run_len(output int n);
    n = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (buf_rst) n++;
      else break;
    end
  endtask

  // Vector: {kind[2:0], enable, ungated, elec_idle, line_valid, expect_fire}
  // kind: 0 rate, 1 bond master, 2 bond level, 3 realign, 4 manual, 5 bond slave
  localparam int NV = 13;
  localparam logic [7:0] VEC [NV] = '{
    8'b000_1_0_0_1_1, 8'b000_0_0_0_1_0,
    8'b001_1_0_0_1_1, 8'b001_0_0_0_1_0,
    8'b101_1_0_0_1_1,
    8'b010_1_0_0_1_1, 8'b010_0_0_0_1_0,
    8'b011_1_0_0_1_1, 8'b011_1_0_1_1_0, 8'b011_1_0_0_0_0,
    8'b011_1_1_1_0_1, 8'b011_0_1_0_1_0,
    8'b100_0_0_0_1_1
  };

  function automatic string tag_of(input logic [7:0] v);
    case (v[7:5])
      3'd0:         return "R2";
      3'd1, 3'd2, 3'd5: return "R3";
      3'd3:         return (v[3] || v[2] || !v[1]) ? "R5" : "R4";
      default:      return "R1";
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog (all requirements): actual=timeout expected=completion");
    report();
  end

  initial begin
    int n;
    // Reset state
    tick(3);
    chk(buf_rst == 1'b1, "R8 reset holds buf_rst", int'(buf_rst), 1);
    chk(done == 1'b0, "R8 reset holds done low", int'(done), 0);
    rate_sel = 2'd2;  // changed while in reset: must not trigger later (R11)
    en_rate  = 1'b1;
    sys_rst = 1'b0; cdr_rst = 1'b0; full_rst = 1'b0;
    run_len(n);
    chk(n == SYNC + LEN - 1, "R11 release tail only", n, SYNC + LEN - 1);
    tick(10);
    chk(done == 1'b1, "R10 done after release", int'(done), 1);

    // Table walk
    for (int v = 0; v < NV; v++) begin
      logic [7:0] vec;
      int highs;
      int expn;
      vec = VEC[v];
      en_rate = 1'b0; en_bond = 1'b0; en_realign = 1'b0;
      ungated = vec[3];
      eidle   = vec[2];
      case (vec[7:5])
        3'd0:             en_rate = vec[4];
        3'd1, 3'd2, 3'd5: en_bond = vec[4];
        3'd3:             en_realign = vec[4];
        default:          ;
      endcase
      if (!vec[1]) begin
        raw = 1'b0;
        tick(LO + 3);
      end
      tick(8);
      case (vec[7:5])
        3'd0:    rate_sel = rate_sel + 2'd1;
        3'd1:    b_master = ~b_master;
        3'd2:    b_level  = b_level + 3'd1;
        3'd3:    realign  = 1'b1;
        3'd4:    req      = 1'b1;
        default: b_slave  = ~b_slave;
      endcase
      highs = 0;
      for (int i = 0; i < 12; i++) begin
        @(negedge clk);
        if (buf_rst) highs++;
        realign = 1'b0;
        req     = 1'b0;
      end
      expn = vec[0] ? LEN : 0;
      chk(highs == expn, tag_of(vec), highs, expn);
      eidle = 1'b0;
      raw   = 1'b1;
      tick(HI + 8);
    end

    // R9: two rate changes two clocks apart extend one pulse
    en_rate = 1'b1; en_bond = 1'b0; en_realign = 1'b0;
    tick(8);
    begin
      int highs;
      highs = 0;
      rate_sel = rate_sel + 2'd1;
      for (int i = 0; i < 12; i++) begin
        @(negedge clk);
        if (buf_rst) highs++;
        if (i == 1) rate_sel = rate_sel + 2'd1;
      end
      chk(highs == 2 + LEN, "R9 overlap extends", highs, 2 + LEN);
    end

    // R1: manual request held 6 clocks; done low during the pulse (R10)
    tick(8);
    begin
      int highs;
      logic d4;
      highs = 0;
      d4 = 1'b1;
      req = 1'b1;
      for (int i = 0; i < 14; i++) begin
        @(negedge clk);
        if (buf_rst) highs++;
        if (i == 3) d4 = done;
        if (i == 5) req = 1'b0;
      end
      chk(highs == 6 + 3, "R1 held request", highs, 9);
      chk(d4 == 1'b0, "R10 done low in pulse", int'(d4), 0);
    end

    // R6/R7: line qualification and idle reset
    tick(8);
    en_idle = 1'b1;
    raw = 1'b0;
    tick(LO + 5);
    chk(buf_rst == 1'b1, "R7 invalid line holds reset", int'(buf_rst), 1);
    chk(done == 1'b0, "R7 done low while invalid", int'(done), 0);
    begin
      int highs;
      highs = 0;
      raw = 1'b1;
      for (int i = 0; i < 8; i++) begin
        @(negedge clk);
        if (buf_rst) highs++;
        if (i == 1) raw = 1'b0;
      end
      chk(highs == 8, "R6 short high run ignored", highs, 8);
    end
    tick(3);
    raw = 1'b1;
    run_len(n);
    chk(n == HI + LEN - 1, "R6 valid after high run", n, HI + LEN - 1);
    tick(10);
    begin
      int highs;
      highs = 0;
      raw = 1'b0;
      for (int i = 0; i < 12; i++) begin
        @(negedge clk);
        if (buf_rst) highs++;
        if (i == 3) raw = 1'b1;
      end
      chk(highs == 0, "R6 short low run ignored", highs, 0);
    end
    tick(6);
    begin
      int highs;
      highs = 0;
      raw = 1'b0;
      for (int i = 0; i < 16; i++) begin
        @(negedge clk);
        if (buf_rst) highs++;
        if (i == 4) raw = 1'b1;
      end
      chk(highs == HI + LEN - 1, "R6 low run invalidates", highs, HI + LEN - 1);
    end
    en_idle = 1'b0;
    tick(10);

    // R10: done follows the second user clock
    clk2_run = 1'b0;
    tick(20);
    chk(done == 1'b0, "R10 done drops on idle clock", int'(done), 0);
    clk2_run = 1'b1;
    tick(20);
    chk(done == 1'b1, "R10 done returns", int'(done), 1);

    // R8/R11: each asynchronous reset mid-operation
    for (int r = 0; r < 3; r++) begin
      case (r)
        0:       sys_rst  = 1'b1;
        1:       cdr_rst  = 1'b1;
        default: full_rst = 1'b1;
      endcase
      #1;
      chk(buf_rst == 1'b1, "R8 immediate buf_rst", int'(buf_rst), 1);
      chk(done == 1'b0, "R8 immediate done low", int'(done), 0);
      tick(2);
      rate_sel = rate_sel + 2'd1;
      b_level  = b_level + 3'd1;
      tick(1);
      sys_rst = 1'b0; cdr_rst = 1'b0; full_rst = 1'b0;
      run_len(n);
      chk(n == SYNC + LEN - 1, "R11 no false change", n, SYNC + LEN - 1);
      tick(10);
      chk(done == 1'b1, "R10 done after reset", int'(done), 1);
    end

    report();
  end
endmodule